// File: doc/BRIEF.md
# Interrupt Destination Target Resolver

This block takes one interrupt request, described by a destination byte, an addressing-mode bit, a 2-bit shorthand code and a lowest-priority flag, and works out which of a fixed set of interrupt agents should receive it. Each agent supplies three inputs that the block reads live: a physical identifier, an 8-bit logical address and a 4-bit logical model selector. A presence vector marks the agents that exist.

The request is taken on a one-cycle strobe. On the next cycle the block shows a registered target mask with one bit per agent, together with a one-cycle valid pulse and the index of the requesting agent. The mask stays unchanged until the next strobe. Lowest-priority requests are reduced to a single target: the present matching agent with the lowest index.

Top module: `irq_target_resolver`

## Requirements
- R1: Shorthand 0, physical mode (`req_logical`=0), destination 0xFF: the mask holds every present agent.
- R2: Shorthand 0, physical mode, destination other than 0xFF: the mask holds every present agent whose `agent_phys_id` equals the destination. If none matches, the mask is all zero.
- R3: Shorthand 0, logical mode, agent model 4'hF (flat): the agent is selected when (destination & its logical address) is nonzero.
- R4: Shorthand 0, logical mode, agent model 4'h0 (cluster): the agent is selected when destination[7:4] equals logical[7:4] and (destination[3:0] & logical[3:0]) is nonzero.
- R5: In logical mode an agent whose model is neither 4'hF nor 4'h0 is never selected.
- R6: Shorthand 1 selects only the requester, shorthand 2 selects all agents, and shorthand 3 selects all agents except the requester. With a nonzero shorthand, the destination and the mode bit have no effect.
- R7: With `req_lowest`=1, only the lowest-indexed set bit of the computed mask is kept. An empty mask stays empty.
- R8: An agent whose `agent_present` bit is 0 is never selected under any mode or shorthand.
- R9: The mask, `res_valid` and `res_src` update on the clock edge after the edge that samples `req_valid`=1. `res_valid` lasts exactly one cycle, and the mask and source hold their values until the next request. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 0 = physical, 1 = logical addressing |
| req_short | input | 2 | Shorthand code, 0..3 |
| req_lowest | input | 1 | Lowest-priority delivery flag |
| req_src | input | 3 | Index of the requesting agent |
| agent_present | input | 8 | One bit per agent that exists |
| agent_phys_id | input | 64 | Physical ID of each agent, agent i at [8i+7:8i] |
| agent_log_dest | input | 64 | Logical address of each agent, agent i at [8i+7:8i] |
| agent_model | input | 32 | Model selector of each agent, agent i at [4i+3:4i] |
| res_valid | output | 1 | One-cycle result strobe |
| res_mask | output | 8 | Registered target mask |
| res_src | output | 3 | Requester index captured at the strobe |

## Verification
The bench sweeps every shorthand, requester, mode and lowest-priority combination, plus all 256 destinations in both modes, against agents configured as flat, cluster, invalid-model and absent. It targets four kinds of error. A resolver that skipped the presence gate would flag absent agents on broadcast. One that compared the full cluster byte instead of only its upper nibble would miss cluster members. One that let a nonzero shorthand still read the destination would produce masks that vary with it. One that picked the highest bit for lowest-priority delivery would choose the wrong single target. Duplicate physical IDs check that an ID match produces a multi-bit mask rather than a single pick.

// File: rtl/irq_target_pkg.sv
package irq_target_pkg;
    localparam int unsigned NUM_AGENTS = 8;
    localparam int unsigned ID_W       = 8;
    localparam int unsigned MODEL_W    = 4;
    localparam int unsigned SRC_W      = $clog2(NUM_AGENTS);

    typedef enum logic [1:0] {
        SH_FIELD    = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL      = 2'd2,
        SH_OTHERS   = 2'd3
    } shorthand_e;

    localparam logic [MODEL_W-1:0] MODEL_FLAT    = {MODEL_W{1'b1}};
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = {MODEL_W{1'b0}};
    localparam logic [ID_W-1:0]    PHYS_BCAST    = {ID_W{1'b1}};

    typedef struct packed {
        logic                  valid;
        logic [NUM_AGENTS-1:0] mask;
        logic [SRC_W-1:0]      src;
    } result_t;
endpackage

// File: rtl/irq_addr_match.sv
module irq_addr_match
    import irq_target_pkg::*;
#(
    parameter int unsigned N = NUM_AGENTS
) (
    input  logic [ID_W-1:0]      dest,
    input  logic                 logical,
    input  logic [N*ID_W-1:0]    phys_id,
    input  logic [N*ID_W-1:0]    log_dest,
    input  logic [N*MODEL_W-1:0] model,
    output logic [N-1:0]         hit
);
    localparam int unsigned NIB = ID_W / 2;

    for (genvar g = 0; g < N; g++) begin : g_agent
        logic [ID_W-1:0]    pid;
        logic [ID_W-1:0]    lad;
        logic [MODEL_W-1:0] mdl;
        logic               flat_hit;
        logic               clus_hit;
        logic               phys_hit;

        assign pid = phys_id[g*ID_W +: ID_W];
        assign lad = log_dest[g*ID_W +: ID_W];
        assign mdl = model[g*MODEL_W +: MODEL_W];

        always_comb begin
            flat_hit = (mdl == MODEL_FLAT) && ((dest & lad) != '0);
            clus_hit = (mdl == MODEL_CLUSTER)
                     && (dest[ID_W-1:NIB] == lad[ID_W-1:NIB])
                     && ((dest[NIB-1:0] & lad[NIB-1:0]) != '0);
            phys_hit = (dest == PHYS_BCAST) || (dest == pid);
            hit[g]   = logical ? (flat_hit || clus_hit) : phys_hit;
        end
    end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] in_mask,
    output logic [N-1:0] out_mask
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign out_mask[g] = in_mask[g] & ~seen[g];
        assign seen[g+1]   = seen[g] | in_mask[g];
    end
endmodule

// File: rtl/irq_target_resolver.sv
module irq_target_resolver
    import irq_target_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [ID_W-1:0]                 req_dest,
    input  logic                            req_logical,
    input  logic [1:0]                      req_short,
    input  logic                            req_lowest,
    input  logic [SRC_W-1:0]                req_src,
    input  logic [NUM_AGENTS-1:0]           agent_present,
    input  logic [NUM_AGENTS*ID_W-1:0]      agent_phys_id,
    input  logic [NUM_AGENTS*ID_W-1:0]      agent_log_dest,
    input  logic [NUM_AGENTS*MODEL_W-1:0]   agent_model,
    output logic                            res_valid,
    output logic [NUM_AGENTS-1:0]           res_mask,
    output logic [SRC_W-1:0]                res_src
);
    logic [NUM_AGENTS-1:0] addr_hit;
    logic [NUM_AGENTS-1:0] self_bit;
    logic [NUM_AGENTS-1:0] raw_mask;
    logic [NUM_AGENTS-1:0] gated_mask;
    logic [NUM_AGENTS-1:0] low_mask;
    result_t               res_d, res_q;

    irq_addr_match #(.N(NUM_AGENTS)) i_match (
        .dest     (req_dest),
        .logical  (req_logical),
        .phys_id  (agent_phys_id),
        .log_dest (agent_log_dest),
        .model    (agent_model),
        .hit      (addr_hit)
    );

    always_comb begin
        self_bit = '0;
        self_bit[req_src] = 1'b1;
        unique case (shorthand_e'(req_short))
            SH_FIELD:  raw_mask = addr_hit;
            SH_SELF:   raw_mask = self_bit;
            SH_ALL:    raw_mask = '1;
            SH_OTHERS: raw_mask = ~self_bit;
            default:   raw_mask = '0;
        endcase
        gated_mask = raw_mask & agent_present;
    end

    irq_lowest_pick #(.N(NUM_AGENTS)) i_pick (
        .in_mask  (gated_mask),
        .out_mask (low_mask)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.mask = req_lowest ? low_mask : gated_mask;
            res_d.src  = req_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.valid;
    assign res_mask  = res_q.mask;
    assign res_src   = res_q.src;
endmodule

// File: rtl/irq_target_checker.sv
module irq_target_checker
    import irq_target_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_short,
    input  logic                  req_lowest,
    input  logic [SRC_W-1:0]      req_src,
    input  logic [NUM_AGENTS-1:0] agent_present,
    input  logic                  res_valid,
    input  logic [NUM_AGENTS-1:0] res_mask,
    input  logic [SRC_W-1:0]      res_src
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(res_mask) && $stable(res_src))); // R9
    AST_SRC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (res_src == $past(req_src))); // R9
    AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lowest) |=> $onehot0(res_mask)); // R7
    AST_PRESENT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((res_mask & ~$past(agent_present)) == '0)); // R8
    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_short == 2'd1) |=> ($countones(res_mask) <= 1)); // R6
endmodule

bind irq_target_resolver irq_target_checker i_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_short     (req_short),
    .req_lowest    (req_lowest),
    .req_src       (req_src),
    .agent_present (agent_present),
    .res_valid     (res_valid),
    .res_mask      (res_mask),
    .res_src       (res_src)
);

// File: tb/test_irq_target_resolver.sv
module test_irq_target_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_dest = '0;
    logic        req_logical = 1'b0;
    logic [1:0]  req_short = '0;
    logic        req_lowest = 1'b0;
    logic [2:0]  req_src = '0;
    logic [7:0]  agent_present;
    logic [63:0] agent_phys_id;
    logic [63:0] agent_log_dest;
    logic [31:0] agent_model;
    logic        res_valid;
    logic [7:0]  res_mask;
    logic [2:0]  res_src;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_target_resolver i_irq_target_resolver (.*);

    function automatic logic [7:0] model_mask(input logic [7:0] d, input logic lg);
        logic [7:0] m = '0;
        for (int i = 0; i < 8; i++) begin
            logic [7:0] pid = agent_phys_id[i*8 +: 8];
            logic [7:0] la  = agent_log_dest[i*8 +: 8];
            logic [3:0] md  = agent_model[i*4 +: 4];
            if (!lg) m[i] = (d == 8'hFF) || (d == pid);
            else if (md == 4'hF) m[i] = (d & la) != 0;
            else if (md == 4'h0) m[i] = (d[7:4] == la[7:4]) && ((d[3:0] & la[3:0]) != 0);
            else m[i] = 1'b0;
        end
        return m;
    endfunction

    function automatic logic [7:0] expect_mask(input logic [7:0] d, input logic lg,
                                               input logic [1:0] sh, input logic [2:0] s,
                                               input logic lo);
        logic [7:0] m;
        logic [7:0] self_v = 8'd1 << s;
        case (sh)
            2'd0: m = model_mask(d, lg);
            2'd1: m = self_v;
            2'd2: m = 8'hFF;
            default: m = ~self_v;
        endcase
        m &= agent_present;
        if (lo) m = m & (~m + 8'd1);
        return m;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                         input logic [2:0] s, input logic lo, input string tag);
        logic [7:0] e;
        e = expect_mask(d, lg, sh, s, lo);
        @(negedge clk);
        req_valid = 1'b1; req_dest = d; req_logical = lg;
        req_short = sh; req_src = s; req_lowest = lo;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {7'd0, res_valid}, 8'd1);
        check(tag, res_mask, e);
        check({tag, " src"}, {5'd0, res_src}, {5'd0, s});
        // scramble inputs; outputs must hold (R9)
        req_dest = ~d; req_short = ~sh; req_src = ~s;
        @(negedge clk);
        check("R9 hold", res_mask, e);
        check("R9 pulse", {7'd0, res_valid}, 8'd0);
    endtask

    initial begin
        // agents: 0..3 flat, 4..5 cluster, 6 invalid model, 7 absent
        agent_present  = 8'b0111_1111;
        agent_phys_id  = {8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h03, 8'h01, 8'h00};
        agent_log_dest = {8'hFF, 8'h01, 8'h32, 8'h31, 8'h08, 8'h04, 8'h02, 8'h01};
        agent_model    = {4'hF, 4'h5, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF};
        repeat (3) @(negedge clk);
        check("R9 reset mask", res_mask, 8'h00);
        check("R9 reset valid", {7'd0, res_valid}, 8'd0);
        rst_n = 1'b1;

        issue(8'hFF, 1'b0, 2'd0, 3'd0, 1'b0, "R1 broadcast");
        issue(8'h07, 1'b0, 2'd0, 3'd0, 1'b0, "R8 absent id");
        issue(8'h03, 1'b0, 2'd0, 3'd0, 1'b0, "R2 duplicate id");
        issue(8'h42, 1'b0, 2'd0, 3'd0, 1'b0, "R2 no match");
        issue(8'h0C, 1'b1, 2'd0, 3'd0, 1'b0, "R3 flat");
        issue(8'h33, 1'b1, 2'd0, 3'd0, 1'b0, "R4 cluster");
        issue(8'h21, 1'b1, 2'd0, 3'd0, 1'b0, "R4 wrong cluster");
        issue(8'h01, 1'b1, 2'd0, 3'd0, 1'b0, "R5 invalid model");
        issue(8'hFF, 1'b0, 2'd0, 3'd0, 1'b1, "R7 lowest");
        issue(8'h42, 1'b0, 2'd0, 3'd0, 1'b1, "R7 empty");
        for (int s = 0; s < 8; s++)
            for (int sh = 1; sh < 4; sh++)
                for (int lo = 0; lo < 2; lo++)
                    issue(8'h5A, s[0], sh[1:0], s[2:0], lo[0], "R6 shorthand");
        for (int lg = 0; lg < 2; lg++)
            for (int d = 0; d < 256; d++)
                issue(d[7:0], lg[0], 2'd0, 3'd2, d[0] ^ d[3], "R3 R4 R2 sweep");
        agent_present = 8'b1010_0101;
        for (int sh = 0; sh < 4; sh++)
            issue(8'hFF, 1'b0, sh[1:0], 3'd2, 1'b0, "R8 presence");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule